// File: doc/BRIEF.md
# Parallel Bit Extract and Deposit Unit

This unit runs two bit-level operations on a 64-bit word, and a mask operand steers both of them. Extract picks out the data bits that sit under ones in the mask. It packs them into the low end of the result and keeps their order. Deposit does the reverse. It takes the low-order data bits in order and places them at the positions where the mask holds a one. A one-bit select chooses the operation. The result is registered, and a valid flag travels with it.

Each operation passes through a log-depth network of conditional swap stages. Deposit uses a butterfly, which swaps across the widest distance first. Extract uses an inverse butterfly, which applies the same stages in the reverse order. One shared generator derives the swap controls for every stage from running population counts of the mask. Because both networks receive the same controls, extract is the exact inverse of deposit on the selected positions.

Top module: `pbx_unit`

## Requirements
- R1: While reset is held and after it is released, and before the first valid input, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` is 1 in the cycle after the cycle in which `in_valid` is 1, and 0 in the cycle after a cycle with `in_valid` at 0.
- R3: With `in_op` = 0 (extract), result bit k equals the data bit at the k-th lowest position where the mask is one, for k from 0 up to p-1, where p is the number of mask ones.
- R4: With `in_op` = 0, every result bit at index p or above is 0.
- R5: With `in_op` = 1 (deposit), the k-th lowest position where the mask is one receives data bit k.
- R6: With `in_op` = 1, every result bit where the mask is 0 is 0.
- R7: An all-zero mask gives an all-zero result for both operations.
- R8: An all-ones mask returns the data unchanged for both operations.
- R9: In a cycle with `in_valid` at 0, `out_result` keeps its previous value, whatever the data, mask and op inputs hold.
- R10: Operations that arrive in consecutive cycles with alternating `in_op` each produce their own correct result, one cycle later, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| in_op | input | 1 | 0 = extract, 1 = deposit |
| in_data | input | 64 | Data operand |
| in_mask | input | 64 | Selection mask |
| out_valid | output | 1 | Result register holds a new result |
| out_result | output | 64 | Registered result |

## Verification
Extract and deposit share the control generator, and one result register captures whichever of them is selected. The two can therefore follow each other with no idle cycle. The bench issues a stream of operations with no gaps that switches between extract and deposit every cycle, using fresh random operands each time. In every cycle it compares the registered result with a bit-serial software model of the operation issued one cycle earlier. Any leak between the two paths, or any slip in the latency, appears as a mismatch against the neighbouring operation's expected value.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

   typedef enum logic {
      PBX_EXTRACT = 1'b0,
      PBX_DEPOSIT = 1'b1
   } pbx_op_e;

   function automatic bit pbx_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pbx_ctrl.sv
// Derives per-stage swap controls for the butterfly pair from the mask.
// Stage s works on aligned blocks of width 2^(s+1); the control for lane j
// of block k lives at bit s*(W/2) + k*2^s + j.
module pbx_ctrl #(
   parameter int W = 64
) (
   input  logic [W-1:0]                  mask,
   output logic [$clog2(W)*(W/2)-1:0]    ctl
);
   localparam int STG  = $clog2(W);
   localparam int CW   = STG + 1;
   localparam int HALF = W / 2;

   if (!pbx_pkg::pbx_is_pow2(W)) begin : g_bad_width
      $error("pbx_ctrl: W must be a power of two, at least 2");
   end

   // pre[i] = number of mask ones strictly below bit i
   logic [CW-1:0] pre [W+1];

   always_comb begin
      logic [CW-1:0] acc;
      acc    = '0;
      pre[0] = '0;
      for (int i = 0; i < W; i++) begin
         acc      = acc + CW'(mask[i]);
         pre[i+1] = acc;
      end
   end

   for (genvar gs = 0; gs < STG; gs++) begin : g_stg
      localparam int BW = 2 ** (gs + 1);
      localparam int HB = BW / 2;
      for (genvar gk = 0; gk < W / BW; gk++) begin : g_blk
         logic [CW-1:0] cnt_lo;   // ones in the lower half of the block
         logic [CW-1:0] cnt_all;  // ones in the whole block
         logic [CW-1:0] rot;      // offset of the block's first element
         assign cnt_lo  = pre[gk*BW+HB] - pre[gk*BW];
         assign cnt_all = pre[gk*BW+BW] - pre[gk*BW];
         assign rot     = pre[gk*BW] & CW'(BW - 1);
         for (genvar gj = 0; gj < HB; gj++) begin : g_lane
            logic [CW-1:0] t_lo, t_hi;
            // element rank held at the low and high lane of this pair
            assign t_lo = (CW'(gj) - rot) & CW'(BW - 1);
            assign t_hi = (CW'(gj + HB) - rot) & CW'(BW - 1);
            assign ctl[gs*HALF + gk*HB + gj] =
               (t_hi < cnt_lo) || ((t_lo >= cnt_lo) && (t_lo < cnt_all));
         end
      end
   end

endmodule

// File: rtl/pbx_net.sv
// Log-depth swap network. INVERSE = 0: widest stage first (butterfly);
// INVERSE = 1: narrowest stage first (inverse butterfly).
module pbx_net #(
   parameter int W       = 64,
   parameter bit INVERSE = 1'b0
) (
   input  logic [W-1:0]                  din,
   input  logic [$clog2(W)*(W/2)-1:0]    ctl,
   output logic [W-1:0]                  dout
);
   localparam int STG  = $clog2(W);
   localparam int HALF = W / 2;

   if (!pbx_pkg::pbx_is_pow2(W)) begin : g_bad_width
      $error("pbx_net: W must be a power of two, at least 2");
   end

   for (genvar gi = 0; gi < STG; gi++) begin : g_lvl
      localparam int S  = INVERSE ? gi : (STG - 1 - gi);
      localparam int BW = 2 ** (S + 1);
      localparam int HB = BW / 2;
      logic [W-1:0] src, nxt;

      if (gi == 0) begin : g_first
         assign src = din;
      end else begin : g_chain
         assign src = g_lvl[gi-1].nxt;
      end

      for (genvar gk = 0; gk < W / BW; gk++) begin : g_blk
         for (genvar gj = 0; gj < HB; gj++) begin : g_lane
            localparam int LO = gk*BW + gj;
            localparam int HI = LO + HB;
            logic swp;
            assign swp     = ctl[S*HALF + gk*HB + gj];
            assign nxt[LO] = swp ? src[HI] : src[LO];
            assign nxt[HI] = swp ? src[LO] : src[HI];
         end
      end
   end

   assign dout = g_lvl[STG-1].nxt;

endmodule

// File: rtl/pbx_unit.sv
module pbx_unit #(
   parameter int W = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_op,
   input  logic [W-1:0]  in_data,
   input  logic [W-1:0]  in_mask,
   output logic          out_valid,
   output logic [W-1:0]  out_result
);
   import pbx_pkg::*;

   localparam int CTLW = $clog2(W) * (W / 2);

   if (!pbx_is_pow2(W)) begin : g_bad_width
      $error("pbx_unit: W must be a power of two, at least 2");
   end

   pbx_op_e      op_sel;
   logic [CTLW-1:0] ctl;
   logic [W-1:0] ext_out, dep_raw, dep_out, nxt_result;

   assign op_sel = pbx_op_e'(in_op);

   pbx_ctrl #(.W(W)) u_ctrl (
      .mask (in_mask),
      .ctl  (ctl)
   );

   // extract: clear unselected bits, then undo the deposit permutation
   pbx_net #(.W(W), .INVERSE(1'b1)) u_ext (
      .din  (in_data & in_mask),
      .ctl  (ctl),
      .dout (ext_out)
   );

   // deposit: permute, then clear lanes outside the mask
   pbx_net #(.W(W), .INVERSE(1'b0)) u_dep (
      .din  (in_data),
      .ctl  (ctl),
      .dout (dep_raw)
   );

   assign dep_out    = dep_raw & in_mask;
   assign nxt_result = (op_sel == PBX_DEPOSIT) ? dep_out : ext_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= nxt_result;
      end
   end

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));
   p_ext_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op) |=>
         $countones(out_result) == $countones($past(in_data & in_mask)));
   p_ext_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op) |=>
         (out_result >> $countones($past(in_mask))) == '0);
   p_dep_offmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op) |=> (out_result & ~$past(in_mask)) == '0);
   p_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (&in_mask)) |=> out_result == $past(in_data));
   p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_mask == '0)) |=> out_result == '0);

endmodule

// File: tb/pbx_unit_tb.sv
module pbx_unit_tb;
   localparam int W = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_op = 1'b0;
   logic [W-1:0]  in_data = '0;
   logic [W-1:0]  in_mask = '0;
   logic          out_valid;
   logic [W-1:0]  out_result;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pbx_unit #(.W(W)) u_dut (
      .clk, .rst_n, .in_valid, .in_op, .in_data, .in_mask,
      .out_valid, .out_result
   );

   // stimulus table: {op, data, mask}
   localparam logic [128:0] VEC [8] = '{
      {1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0F0F_0F0F_0F0F_0F0F},
      {1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0F0F_0F0F_0F0F_0F0F},
      {1'b0, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001},
      {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555},
      {1'b0, 64'hA5A5_A5A5_5A5A_5A5A, 64'hFFFF_0000_FFFF_0000},
      {1'b1, 64'h0000_0000_0000_B3C7, 64'hF0F0_0FF0_1234_8001},
      {1'b0, 64'h7E57_DA7A_0BAD_CAFE, 64'h0000_0000_0000_0000},
      {1'b1, 64'h7E57_DA7A_0BAD_CAFE, 64'hFFFF_FFFF_FFFF_FFFF}
   };

   function automatic logic [W-1:0] ref_ext(input logic [W-1:0] d, m);
      logic [W-1:0] r = '0;
      int k = 0;
      for (int i = 0; i < W; i++) if (m[i]) begin r[k] = d[i]; k++; end
      return r;
   endfunction

   function automatic logic [W-1:0] ref_dep(input logic [W-1:0] d, m);
      logic [W-1:0] r = '0;
      int k = 0;
      for (int i = 0; i < W; i++) if (m[i]) begin r[i] = d[k]; k++; end
      return r;
   endfunction

   function automatic logic [W-1:0] ref_op(input logic op, input logic [W-1:0] d, m);
      return op ? ref_dep(d, m) : ref_ext(d, m);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic run_one(input logic op, input logic [W-1:0] d, m, input string req);
      logic [W-1:0] e;
      e = ref_op(op, d, m);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_data = d; in_mask = m;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, out_result, e);
      check("R2", {{(W-1){1'b0}}, out_valid}, 64'd1);
   endtask

   task automatic rand_word(output logic [W-1:0] w);
      w = {$urandom, $urandom};
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] d, m, last, pend;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", {{(W-1){1'b0}}, out_valid}, '0);
      check("R1", out_result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {{(W-1){1'b0}}, out_valid}, '0);
      check("R1", out_result, '0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         run_one(VEC[i][128], VEC[i][127:64], VEC[i][63:0],
                 VEC[i][128] ? "R5,R6" : "R3,R4");
      end

      // random operands, dense and sparse masks
      for (int i = 0; i < 40; i++) begin
         rand_word(d); rand_word(m);
         if (i % 3 == 2) m = m & {$urandom, $urandom} & {$urandom, $urandom};
         run_one(i[0], d, m, i[0] ? "R5,R6" : "R3,R4");
      end

      // corner masks
      rand_word(d);
      run_one(1'b0, d, '0, "R7");
      run_one(1'b1, d, '0, "R7");
      run_one(1'b0, d, '1, "R8");
      run_one(1'b1, d, '1, "R8");
      run_one(1'b0, d, 64'h8000_0000_0000_0000, "R3,R4");
      run_one(1'b1, 64'h1, 64'h8000_0000_0000_0000, "R5,R6");
      run_one(1'b1, 64'h1, 64'h0000_0000_0000_0001, "R5,R6");
      run_one(1'b0, d, 64'hAAAA_AAAA_AAAA_AAAA, "R3,R4");
      run_one(1'b1, d, 64'hAAAA_AAAA_AAAA_AAAA, "R5,R6");

      // R9: inputs ignored while in_valid is low
      run_one(1'b0, 64'hFEDC_BA98_7654_3210, 64'hFF00_FF00_00FF_00FF, "R3,R4");
      last = ref_ext(64'hFEDC_BA98_7654_3210, 64'hFF00_FF00_00FF_00FF);
      for (int i = 0; i < 4; i++) begin
         rand_word(d); rand_word(m);
         in_op = i[0]; in_data = d; in_mask = m;
         @(negedge clk);
         check("R9", out_result, last);
         check("R2", {{(W-1){1'b0}}, out_valid}, '0);
      end

      // R10: back-to-back, alternating operation every cycle
      pend = '0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check("R10", out_result, pend);
            check("R2", {{(W-1){1'b0}}, out_valid}, 64'd1);
         end
         rand_word(d); rand_word(m);
         in_valid = 1'b1; in_op = i[0]; in_data = d; in_mask = m;
         pend = ref_op(i[0], d, m);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", out_result, pend);
      @(negedge clk);
      check("R2", {{(W-1){1'b0}}, out_valid}, '0);
      check("R9", out_result, pend);

      summary();
      $finish;
   end

endmodule